// File: doc/BRIEF.md
# Active Priority Bitmap Tracker

This block records which priority levels are currently in service for two interrupt groups. Each group owns a bitmap with one bit per implemented priority level, stored as one to four 32-bit words. When an interrupt is taken, the caller presents its group and its priority with the subpriority bits already masked off. The block sets the bit that stands for that level.

When an interrupt finishes, the caller issues a drop. The block finds the lowest set bit across both groups and clears it. It then reports the priority that bit stood for, together with the group it came from. A combinational running-priority output always shows the most urgent level still in service.

The number of implemented priority bits, `PRIO_BITS` (5, 6 or 7), sets the bitmap size and the shift between a priority value and its bit index. A synchronous clear empties both bitmaps at once.

Top module: `apt_tracker`

## Requirements
- R1: After reset both bitmaps are empty, `run_prio_o` and `drop_prio_o` read 0xFF, `drop_grp_o` reads 0 and `drop_done_o` is low.
- R2: An activate sets bit `act_prio_i >> (8 - PRIO_BITS)` in the bitmap of group `act_grp_i` (0 = group 0, 1 = group 1). The low `8 - PRIO_BITS` bits of `act_prio_i` have no effect, so with `PRIO_BITS` = 7 a priority of 0x51 is later reported as 0x50.
- R3: A drop clears the lowest set bit across both bitmaps. One cycle later it presents on `drop_prio_o` that bit's index shifted left by `8 - PRIO_BITS`, and on `drop_grp_o` the group whose bit was cleared.
- R4: When both groups have the same lowest bit set, the drop clears the group 0 bit first and reports `drop_grp_o` = 0.
- R5: A drop while both bitmaps are empty reports 0xFF with `drop_grp_o` = 0 and changes no state.
- R6: The drop scans the words from word 0 upward and skips words that are empty in both groups. Bits in higher words, indices 32 and up, are found only when all lower words are empty. A bit at index 31 is therefore dropped before one at index 32.
- R7: `run_prio_o` always equals the priority of the lowest set bit in either bitmap, or 0xFF when both are empty.
- R8: `clr_i` empties both bitmaps in one cycle and takes precedence over an activate in the same cycle.
- R9: Activating a level that is already set leaves the bitmap unchanged, so a single drop clears it.
- R10: `drop_done_o` is high for exactly the one cycle after each drop request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_i | input | 1 | Synchronous clear of both bitmaps |
| act_valid_i | input | 1 | Activate request |
| act_grp_i | input | 1 | Group of the activate (0 or 1) |
| act_prio_i | input | 8 | Masked priority of the activated interrupt |
| drop_valid_i | input | 1 | Drop request, never together with an activate |
| drop_prio_o | output | 8 | Priority cleared by the last drop, 0xFF if none |
| drop_grp_o | output | 1 | Group cleared by the last drop |
| drop_done_o | output | 1 | One-cycle strobe marking a drop result |
| run_prio_o | output | 8 | Highest-urgency priority in service, 0xFF if idle |

## Verification
On every cycle the assertions check the following: the drop strobe follows each request, a drop reports the running priority it saw, a drop never makes the running priority more urgent, an activate leaves the tracker non-idle, and a clear leaves it idle. The directed scenarios are needed for the rest. They show which group loses a tie, that the subpriority bits are discarded, that the scan crosses word boundaries in order, and that duplicate activates collapse into a single level. They also check the exact values reported for each drop order.

// File: rtl/apt_pkg.sv
package apt_pkg;
   typedef logic [7:0] prio_t;
   localparam prio_t IDLE_PRIO = 8'hFF;
   localparam int    WORD_BITS = 32;
endpackage

// File: rtl/apt_lowest.sv
module apt_lowest #(
   parameter int W    = 32,
   parameter int IDXW = $clog2(W)
) (
   input  logic [W-1:0]    vec_i,
   output logic            found_o,
   output logic [IDXW-1:0] idx_o
);
   always_comb begin
      found_o = 1'b0;
      idx_o   = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec_i[i]) begin
            found_o = 1'b1;
            idx_o   = IDXW'(i);
         end
      end
   end
endmodule

// File: rtl/apt_bitmap.sv
module apt_bitmap #(
   parameter int NBITS = 128,
   parameter int IDXW  = $clog2(NBITS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             set_en_i,
   input  logic [IDXW-1:0]  set_idx_i,
   input  logic             unset_en_i,
   input  logic [IDXW-1:0]  unset_idx_i,
   output logic [NBITS-1:0] map_o
);
   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
         map_o <= '0;
      end else begin
         if (unset_en_i) map_o[unset_idx_i] <= 1'b0;
         if (set_en_i)   map_o[set_idx_i]   <= 1'b1;
      end
   end
endmodule

// File: rtl/apt_tracker.sv
module apt_tracker
   import apt_pkg::*;
#(
   parameter int PRIO_BITS = 7
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr_i,
   input  logic       act_valid_i,
   input  logic       act_grp_i,
   input  logic [7:0] act_prio_i,
   input  logic       drop_valid_i,
   output logic [7:0] drop_prio_o,
   output logic       drop_grp_o,
   output logic       drop_done_o,
   output logic [7:0] run_prio_o
);
   localparam int NWORDS  = 1 << (PRIO_BITS - 5);
   localparam int NBITS   = NWORDS * WORD_BITS;
   localparam int IDXW    = PRIO_BITS;
   localparam int POSW    = $clog2(WORD_BITS);
   localparam int MIN_BPR = 7 - PRIO_BITS;
   localparam int SHIFT   = MIN_BPR + 1;

   generate
      if (PRIO_BITS < 5 || PRIO_BITS > 7) begin : g_bad_prio_bits
         $error("apt_tracker: PRIO_BITS must lie in 5..7");
      end
   endgenerate

   logic [NBITS-1:0] map [2];
   logic [IDXW-1:0]  act_idx;
   logic [IDXW-1:0]  hit_idx;
   logic             hit_any;
   logic             hit_grp;

   assign act_idx = IDXW'(act_prio_i >> SHIFT);

   // one storage bank per group
   for (genvar g = 0; g < 2; g++) begin : g_grp
      apt_bitmap #(.NBITS(NBITS), .IDXW(IDXW)) u_map (
         .clk         (clk),
         .rst_n       (rst_n),
         .clr_i       (clr_i),
         .set_en_i    (act_valid_i && (act_grp_i == 1'(g))),
         .set_idx_i   (act_idx),
         .unset_en_i  (drop_valid_i && hit_any && (hit_grp == 1'(g))),
         .unset_idx_i (hit_idx),
         .map_o       (map[g])
      );
   end

   // per-word trailing-zero compare, group 0 wins ties
   logic [NWORDS-1:0] w_any;
   logic [NWORDS-1:0] w_grp;
   logic [POSW-1:0]   w_pos [NWORDS];

   for (genvar w = 0; w < NWORDS; w++) begin : g_word
      logic            f0, f1;
      logic [POSW-1:0] i0, i1;
      logic [POSW:0]   tz0, tz1;

      apt_lowest #(.W(WORD_BITS), .IDXW(POSW)) u_low0 (
         .vec_i (map[0][w*WORD_BITS +: WORD_BITS]), .found_o (f0), .idx_o (i0));
      apt_lowest #(.W(WORD_BITS), .IDXW(POSW)) u_low1 (
         .vec_i (map[1][w*WORD_BITS +: WORD_BITS]), .found_o (f1), .idx_o (i1));

      assign tz0      = f0 ? {1'b0, i0} : (POSW+1)'(WORD_BITS);
      assign tz1      = f1 ? {1'b0, i1} : (POSW+1)'(WORD_BITS);
      assign w_any[w] = f0 || f1;
      assign w_grp[w] = !(tz0 <= tz1);
      assign w_pos[w] = (tz0 <= tz1) ? i0 : i1;
   end

   // first non-empty word in ascending order
   always_comb begin
      hit_any = 1'b0;
      hit_grp = 1'b0;
      hit_idx = '0;
      for (int w = NWORDS - 1; w >= 0; w--) begin
         if (w_any[w]) begin
            hit_any = 1'b1;
            hit_grp = w_grp[w];
            hit_idx = IDXW'(w * WORD_BITS) + IDXW'(w_pos[w]);
         end
      end
   end

   assign run_prio_o = hit_any ? 8'(32'(hit_idx) << SHIFT) : IDLE_PRIO;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         drop_prio_o <= IDLE_PRIO;
         drop_grp_o  <= 1'b0;
         drop_done_o <= 1'b0;
      end else begin
         drop_done_o <= drop_valid_i;
         if (drop_valid_i) begin
            drop_prio_o <= run_prio_o;
            drop_grp_o  <= hit_any && hit_grp;
         end
      end
   end

   // R10: strobe follows each drop request by one cycle
   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      drop_valid_i |=> drop_done_o);
   a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !drop_valid_i |=> !drop_done_o);
   // R3: drop reports the running priority seen at the request
   a_r3_drop_value: assert property (@(posedge clk) disable iff (!rst_n)
      drop_valid_i |=> drop_prio_o == $past(run_prio_o));
   // R3: a drop never makes the running priority more urgent
   a_r3_drop_monotone: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_valid_i && !act_valid_i && !clr_i) |=> run_prio_o >= $past(run_prio_o));
   // R2: after an activate the tracker is not idle
   a_r2_act_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (act_valid_i && !clr_i) |=> run_prio_o != IDLE_PRIO);
   // R8: clear leaves the tracker idle
   a_r8_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> run_prio_o == IDLE_PRIO);
   // R7: idle output exactly when both maps are empty
   a_r7_idle_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (map[0] == '0 && map[1] == '0) == (run_prio_o == IDLE_PRIO));
   // R2: activate and drop are exclusive
   a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(act_valid_i && drop_valid_i));
endmodule

// File: tb/apt_tracker_tb.sv
module apt_tracker_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       clr_i = 1'b0;
   logic       act_valid_i = 1'b0;
   logic       act_grp_i = 1'b0;
   logic [7:0] act_prio_i = '0;
   logic       drop_valid_i = 1'b0;
   logic [7:0] drop_prio_o;
   logic       drop_grp_o;
   logic       drop_done_o;
   logic [7:0] run_prio_o;

   int n_checks = 0;
   int n_fail   = 0;

   always #5 clk = ~clk;

   apt_tracker #(.PRIO_BITS(7)) u_dut (.*);

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic do_act(input logic g, input logic [7:0] p);
      act_valid_i = 1'b1; act_grp_i = g; act_prio_i = p;
      @(negedge clk);
      act_valid_i = 1'b0;
   endtask

   // drop and check reported priority and group, plus the strobe (R10)
   task automatic do_drop(input string req, input int ep, input int eg);
      drop_valid_i = 1'b1;
      @(negedge clk);
      drop_valid_i = 1'b0;
      check(req, drop_prio_o, ep);
      check(req, drop_grp_o, eg);
      check("R10 strobe high", drop_done_o, 1);
      @(negedge clk);
      check("R10 strobe one cycle", drop_done_o, 0);
   endtask

   task automatic t_reset;
      check("R1 run", run_prio_o, 8'hFF);
      check("R1 drop prio", drop_prio_o, 8'hFF);
      check("R1 drop grp", drop_grp_o, 0);
      check("R1 strobe", drop_done_o, 0);
   endtask

   task automatic t_basic;
      do_act(1'b1, 8'h51);
      check("R2 subpriority ignored", run_prio_o, 8'h50);
      do_act(1'b0, 8'h23);
      check("R7 lowest wins", run_prio_o, 8'h22);
      do_drop("R3 first drop", 8'h22, 0);
      check("R7 after drop", run_prio_o, 8'h50);
      do_drop("R3 second drop", 8'h50, 1);
      check("R7 empty", run_prio_o, 8'hFF);
   endtask

   task automatic t_tie;
      do_act(1'b1, 8'h10);
      do_act(1'b0, 8'h10);
      do_drop("R4 group 0 first", 8'h10, 0);
      check("R4 other remains", run_prio_o, 8'h10);
      do_drop("R4 group 1 next", 8'h10, 1);
   endtask

   task automatic t_empty;
      do_drop("R5 empty drop", 8'hFF, 0);
      check("R5 stays idle", run_prio_o, 8'hFF);
   endtask

   task automatic t_words;
      do_act(1'b0, 8'hFE);
      do_act(1'b1, 8'h80);
      do_act(1'b0, 8'h40);
      do_act(1'b1, 8'h3E);
      do_drop("R6 index 31 before 32", 8'h3E, 1);
      do_drop("R6 word 1", 8'h40, 0);
      do_drop("R6 word 2", 8'h80, 1);
      do_drop("R6 word 3", 8'hFE, 0);
      do_drop("R6 all empty", 8'hFF, 0);
   endtask

   task automatic t_clear;
      do_act(1'b0, 8'h08);
      do_act(1'b1, 8'hA0);
      clr_i = 1'b1; act_valid_i = 1'b1; act_grp_i = 1'b0; act_prio_i = 8'h04;
      @(negedge clk);
      clr_i = 1'b0; act_valid_i = 1'b0;
      check("R8 cleared", run_prio_o, 8'hFF);
      do_drop("R8 nothing left", 8'hFF, 0);
   endtask

   task automatic t_dup;
      do_act(1'b0, 8'h30);
      do_act(1'b0, 8'h31);
      do_drop("R9 single level", 8'h30, 0);
      check("R9 gone", run_prio_o, 8'hFF);
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_tie();
      t_empty();
      t_words();
      t_clear();
      t_dup();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule